// File: doc/BRIEF.md
# Retirement Stall Cycle Accountant

This unit watches the stream of retired instructions of a simple in-order core and keeps a running cycle estimate. Each accepted descriptor carries an instruction class, up to two source register numbers (each with a valid bit), a destination register, a branch-taken flag, a base cycle count, and first/last flags that mark a parallel issue group. From these the unit works out two penalties. A load-use penalty applies when a source reads a register loaded by the previous instruction. A fixed penalty applies to taken branches. It then folds the instructions of a parallel pair into one cycle contribution.

Five wrapping counters are kept: overall cycles, load-use stall cycles, branch stall cycles, taken branches and untaken branches. A single register mask records which registers were loaded recently. It is cleared when a new issue group starts, so a load can stall only the instructions that follow it in the same group or the first instruction of the next group. The unit accepts one descriptor per clock cycle under a valid strobe and has no other control.

Top module: `stall_acct`

## Requirements
- R1: A synchronous, active-high reset clears all five counters to zero and forgets every recorded load.
- R2: Each valid source register whose bit is set in the recorded load mask adds 2 cycles to the instruction's load stall, so two such sources add 4. Every accepted instruction adds its load stall to the load-stall counter. Class encoding is 0 exec, 1 compare, 2 mac, 3 branch, 4 load, 5 store; codes 6 and 7 behave as exec.
- R3: After each accepted instruction the mask becomes the previous mask, or zero when the instruction has the first flag, with the destination bit of a load (class 4) set. A source whose valid bit is 0 never stalls.
- R4: A taken branch (class 3, taken flag 1) adds 2 to the branch-stall counter and 1 to the taken counter. An untaken branch adds 1 to the untaken counter and nothing else.
- R5: An instruction's total is its base cycles plus its load stall plus its branch stall. An instruction with both the first and last flags adds its total to the overall cycle counter.
- R6: An instruction without the last flag adds nothing to the overall counter and holds its total as the group maximum. An instruction with the last flag adds the larger of its total and the held maximum. The held maximum counts as zero when that instruction also has the first flag.
- R7: The load-stall and branch-stall counters take the stalls of every instruction, including those whose total loses the group maximum.
- R8: A cycle without the valid strobe changes neither the counters nor the recorded load mask.
- R9: All counters are registered and show the effect of a descriptor one clock edge after it is accepted, not before.
- R10: The taken flag has no effect for any class other than branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | A retired descriptor is present this cycle |
| desc_class | input | 3 | Instruction class code |
| src_a_reg | input | 4 | First source register number |
| src_a_vld | input | 1 | First source register is used |
| src_b_reg | input | 4 | Second source register number |
| src_b_vld | input | 1 | Second source register is used |
| dst_reg | input | 4 | Destination register number |
| br_taken | input | 1 | Branch was taken |
| base_cycles | input | 8 | Base cycle count of the instruction |
| grp_first | input | 1 | Instruction opens an issue group |
| grp_last | input | 1 | Instruction closes an issue group |
| total_cycles | output | 32 | Overall cycle count |
| load_stall_cycles | output | 32 | Accumulated load-use stall cycles |
| branch_stall_cycles | output | 32 | Accumulated taken-branch stall cycles |
| taken_count | output | 32 | Number of taken branches |
| untaken_count | output | 32 | Number of untaken branches |

## Verification
Every counter is due exactly one rising edge after the cycle in which its descriptor is presented. The load mask and the held group maximum act only on the descriptor that follows, in the cycle after. The bench drives each descriptor just after a falling edge, drops the strobe two nanoseconds after the capturing rising edge, and reads all counters there. For the latency requirement it also reads the counters before that edge, where they must still hold their old values. Mask effects are checked one descriptor later, including across an idle gap and across a reset.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;

  typedef enum logic [2:0] {
    CLS_EXEC   = 3'd0,
    CLS_CMP    = 3'd1,
    CLS_MAC    = 3'd2,
    CLS_BRANCH = 3'd3,
    CLS_LOAD   = 3'd4,
    CLS_STORE  = 3'd5
  } instr_class_e;

  // Counter slots in the accumulator bank
  localparam int CNT_TOTAL   = 0;
  localparam int CNT_LSTALL  = 1;
  localparam int CNT_BSTALL  = 2;
  localparam int CNT_TAKEN   = 3;
  localparam int CNT_UNTAKEN = 4;
  localparam int NUM_CNT     = 5;

  // Source operands per descriptor
  localparam int NUM_SRC = 2;

endpackage

// File: rtl/stall_acct_hazard.sv
// Recorded-load mask and load-use stall calculation.
module stall_acct_hazard #(
  parameter int NUM_REGS = 16,
  parameter int NUM_SRC  = 2,
  parameter int PENALTY  = 2,
  parameter int STALL_W  = 3,
  parameter int REG_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               grp_first,
  input  logic               is_load,
  input  logic [REG_W-1:0]   dst_reg,
  input  logic [REG_W-1:0]   src_reg [NUM_SRC],
  input  logic               src_vld [NUM_SRC],
  output logic [STALL_W-1:0] stall
);

  logic [NUM_REGS-1:0] load_mask;
  logic [NUM_REGS-1:0] load_mask_nxt;
  logic [NUM_SRC-1:0]  src_hit;

  // One hit detector per source operand
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign src_hit[s] = src_vld[s] && load_mask[src_reg[s]];
  end

  always_comb begin
    stall = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (src_hit[s]) stall = stall + STALL_W'(PENALTY);
    end
  end

  always_comb begin
    load_mask_nxt = grp_first ? '0 : load_mask;
    if (is_load) load_mask_nxt[dst_reg] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_mask <= '0;
    end else if (step) begin
      load_mask <= load_mask_nxt;
    end
  end

endmodule

// File: rtl/stall_acct_merge.sv
// Folds the instructions of one issue group into a single cycle contribution.
module stall_acct_merge #(
  parameter int TOT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             grp_first,
  input  logic             grp_last,
  input  logic [TOT_W-1:0] instr_total,
  output logic             contrib_en,
  output logic [TOT_W-1:0] contrib
);

  logic [TOT_W-1:0] held_max;
  logic [TOT_W-1:0] held_eff;

  assign held_eff   = grp_first ? '0 : held_max;
  assign contrib    = (instr_total > held_eff) ? instr_total : held_eff;
  assign contrib_en = step && grp_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_max <= '0;
    end else if (step && !grp_last) begin
      held_max <= instr_total;
    end
  end

endmodule

// File: rtl/stall_acct_counter.sv
// Wrapping accumulator with a narrow increment.
module stall_acct_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (en) begin
      count <= count + CNT_W'(inc);
    end
  end

endmodule

// File: rtl/stall_acct.sv
module stall_acct #(
  parameter int NUM_REGS    = 16,
  parameter int CYC_W       = 8,
  parameter int CNT_W       = 32,
  parameter int LOAD_PEN    = 2,
  parameter int BRANCH_PEN  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        desc_valid,
  input  logic [2:0]                  desc_class,
  input  logic [$clog2(NUM_REGS)-1:0] src_a_reg,
  input  logic                        src_a_vld,
  input  logic [$clog2(NUM_REGS)-1:0] src_b_reg,
  input  logic                        src_b_vld,
  input  logic [$clog2(NUM_REGS)-1:0] dst_reg,
  input  logic                        br_taken,
  input  logic [CYC_W-1:0]            base_cycles,
  input  logic                        grp_first,
  input  logic                        grp_last,
  output logic [CNT_W-1:0]            total_cycles,
  output logic [CNT_W-1:0]            load_stall_cycles,
  output logic [CNT_W-1:0]            branch_stall_cycles,
  output logic [CNT_W-1:0]            taken_count,
  output logic [CNT_W-1:0]            untaken_count
);
  import stall_acct_pkg::*;

  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int LSTALL_W = $clog2(NUM_SRC * LOAD_PEN + 1);
  localparam int TOT_W    = $clog2((2 ** CYC_W) + NUM_SRC * LOAD_PEN + BRANCH_PEN);

  logic [REG_W-1:0]    src_reg [NUM_SRC];
  logic                src_vld [NUM_SRC];
  logic [LSTALL_W-1:0] load_stall;
  logic [TOT_W-1:0]    branch_stall;
  logic [TOT_W-1:0]    instr_total;
  logic                is_load;
  logic                is_branch;
  logic                taken_hit;
  logic                untaken_hit;
  logic                merge_en;
  logic [TOT_W-1:0]    merge_val;

  logic                cnt_en  [NUM_CNT];
  logic [TOT_W-1:0]    cnt_inc [NUM_CNT];
  logic [CNT_W-1:0]    cnt_val [NUM_CNT];

  assign src_reg[0] = src_a_reg;
  assign src_reg[1] = src_b_reg;
  assign src_vld[0] = src_a_vld;
  assign src_vld[1] = src_b_vld;

  assign is_load     = desc_class == CLS_LOAD;
  assign is_branch   = desc_class == CLS_BRANCH;
  assign taken_hit   = desc_valid && is_branch && br_taken;
  assign untaken_hit = desc_valid && is_branch && !br_taken;

  assign branch_stall = taken_hit ? TOT_W'(BRANCH_PEN) : '0;
  assign instr_total  = TOT_W'(base_cycles) + TOT_W'(load_stall) + branch_stall;

  stall_acct_hazard #(
    .NUM_REGS (NUM_REGS),
    .NUM_SRC  (NUM_SRC),
    .PENALTY  (LOAD_PEN),
    .STALL_W  (LSTALL_W),
    .REG_W    (REG_W)
  ) u_hazard (
    .clk       (clk),
    .rst       (rst),
    .step      (desc_valid),
    .grp_first (grp_first),
    .is_load   (is_load),
    .dst_reg   (dst_reg),
    .src_reg   (src_reg),
    .src_vld   (src_vld),
    .stall     (load_stall)
  );

  stall_acct_merge #(
    .TOT_W (TOT_W)
  ) u_merge (
    .clk         (clk),
    .rst         (rst),
    .step        (desc_valid),
    .grp_first   (grp_first),
    .grp_last    (grp_last),
    .instr_total (instr_total),
    .contrib_en  (merge_en),
    .contrib     (merge_val)
  );

  always_comb begin
    cnt_en[CNT_TOTAL]    = merge_en;
    cnt_inc[CNT_TOTAL]   = merge_val;
    cnt_en[CNT_LSTALL]   = desc_valid;
    cnt_inc[CNT_LSTALL]  = TOT_W'(load_stall);
    cnt_en[CNT_BSTALL]   = taken_hit;
    cnt_inc[CNT_BSTALL]  = branch_stall;
    cnt_en[CNT_TAKEN]    = taken_hit;
    cnt_inc[CNT_TAKEN]   = TOT_W'(1);
    cnt_en[CNT_UNTAKEN]  = untaken_hit;
    cnt_inc[CNT_UNTAKEN] = TOT_W'(1);
  end

  for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
    stall_acct_counter #(
      .CNT_W (CNT_W),
      .INC_W (TOT_W)
    ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .en    (cnt_en[c]),
      .inc   (cnt_inc[c]),
      .count (cnt_val[c])
    );
  end

  assign total_cycles        = cnt_val[CNT_TOTAL];
  assign load_stall_cycles   = cnt_val[CNT_LSTALL];
  assign branch_stall_cycles = cnt_val[CNT_BSTALL];
  assign taken_count         = cnt_val[CNT_TAKEN];
  assign untaken_count       = cnt_val[CNT_UNTAKEN];

endmodule

// File: rtl/stall_acct_checker.sv
module stall_acct_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_valid,
  input logic [2:0]       desc_class,
  input logic             grp_last,
  input logic [CNT_W-1:0] total_cycles,
  input logic [CNT_W-1:0] load_stall_cycles,
  input logic [CNT_W-1:0] branch_stall_cycles,
  input logic [CNT_W-1:0] taken_count,
  input logic [CNT_W-1:0] untaken_count
);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !desc_valid |=> ($stable(total_cycles) && $stable(load_stall_cycles) &&
                     $stable(branch_stall_cycles) && $stable(taken_count) &&
                     $stable(untaken_count)));

  assert_even_load_stall_R2: assert property (@(posedge clk) disable iff (rst)
    desc_valid |=> (load_stall_cycles[0] == $past(load_stall_cycles[0])));

  assert_branch_only_R10: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_class != 3'd3) |=>
      ($stable(taken_count) && $stable(untaken_count) && $stable(branch_stall_cycles)));

  assert_branch_counted_R4: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_class == 3'd3) |=>
      ((taken_count + untaken_count) == ($past(taken_count) + $past(untaken_count) + 1)));

  assert_total_on_last_R6: assert property (@(posedge clk) disable iff (rst)
    !(desc_valid && grp_last) |=> $stable(total_cycles));

endmodule

bind stall_acct stall_acct_checker #(.CNT_W(CNT_W)) u_checker (
  .clk                 (clk),
  .rst                 (rst),
  .desc_valid          (desc_valid),
  .desc_class          (desc_class),
  .grp_last            (grp_last),
  .total_cycles        (total_cycles),
  .load_stall_cycles   (load_stall_cycles),
  .branch_stall_cycles (branch_stall_cycles),
  .taken_count         (taken_count),
  .untaken_count       (untaken_count)
);

// File: tb/stall_acct_bench.sv
module stall_acct_bench;

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  sa;
    logic        sav;
    logic [3:0]  sb;
    logic        sbv;
    logic [3:0]  dst;
    logic        tk;
    logic [7:0]  base;
    logic        first;
    logic        last;
    logic [3:0]  req;
    logic [15:0] et;
    logic [15:0] el;
    logic [7:0]  eb;
    logic [7:0]  ek;
    logic [7:0]  eu;
  } vec_t;

  localparam int NV = 22;
  // cls sa sav sb sbv dst tk base first last req | expected totals T L B K U
  localparam vec_t TBL [NV] = '{
    '{3'd4, 4'd1,  1'b1, 4'd0, 1'b0, 4'd3,  1'b0, 8'd1, 1'b1, 1'b1, 4'd5,  16'd1,  16'd0,  8'd0, 8'd0, 8'd0}, // R5
    '{3'd0, 4'd3,  1'b1, 4'd4, 1'b1, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd2,  16'd4,  16'd2,  8'd0, 8'd0, 8'd0}, // R2
    '{3'd0, 4'd3,  1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd3,  16'd5,  16'd2,  8'd0, 8'd0, 8'd0}, // R3
    '{3'd4, 4'd0,  1'b0, 4'd0, 1'b0, 4'd5,  1'b0, 8'd1, 1'b1, 1'b1, 4'd3,  16'd6,  16'd2,  8'd0, 8'd0, 8'd0}, // R3
    '{3'd4, 4'd5,  1'b1, 4'd0, 1'b0, 4'd6,  1'b0, 8'd1, 1'b1, 1'b1, 4'd2,  16'd9,  16'd4,  8'd0, 8'd0, 8'd0}, // R2
    '{3'd5, 4'd6,  1'b1, 4'd6, 1'b1, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd2,  16'd14, 16'd8,  8'd0, 8'd0, 8'd0}, // R2
    '{3'd3, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 8'd1, 1'b1, 1'b1, 4'd4,  16'd17, 16'd8,  8'd2, 8'd1, 8'd0}, // R4
    '{3'd3, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd4,  16'd18, 16'd8,  8'd2, 8'd1, 8'd1}, // R4
    '{3'd0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 8'd2, 1'b1, 1'b1, 4'd10, 16'd20, 16'd8,  8'd2, 8'd1, 8'd1}, // R10
    '{3'd4, 4'd0,  1'b0, 4'd0, 1'b0, 4'd7,  1'b0, 8'd1, 1'b1, 1'b1, 4'd5,  16'd21, 16'd8,  8'd2, 8'd1, 8'd1}, // R5
    '{3'd0, 4'd7,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd3,  16'd22, 16'd8,  8'd2, 8'd1, 8'd1}, // R3
    '{3'd4, 4'd0,  1'b0, 4'd0, 1'b0, 4'd2,  1'b0, 8'd1, 1'b1, 1'b0, 4'd6,  16'd22, 16'd8,  8'd2, 8'd1, 8'd1}, // R6
    '{3'd0, 4'd2,  1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 8'd1, 1'b0, 1'b1, 4'd7,  16'd25, 16'd10, 8'd2, 8'd1, 8'd1}, // R7
    '{3'd0, 4'd2,  1'b1, 4'd0, 1'b0, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd3,  16'd28, 16'd12, 8'd2, 8'd1, 8'd1}, // R3
    '{3'd2, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 8'd6, 1'b1, 1'b0, 4'd6,  16'd28, 16'd12, 8'd2, 8'd1, 8'd1}, // R6
    '{3'd3, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b1, 8'd1, 1'b0, 1'b1, 4'd7,  16'd34, 16'd12, 8'd4, 8'd2, 8'd1}, // R7
    '{3'd1, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 8'd2, 1'b1, 1'b0, 4'd6,  16'd34, 16'd12, 8'd4, 8'd2, 8'd1}, // R6
    '{3'd0, 4'd0,  1'b0, 4'd0, 1'b0, 4'd0,  1'b0, 8'd5, 1'b0, 1'b1, 4'd6,  16'd39, 16'd12, 8'd4, 8'd2, 8'd1}, // R6
    '{3'd4, 4'd0,  1'b0, 4'd0, 1'b0, 4'd9,  1'b0, 8'd1, 1'b1, 1'b0, 4'd6,  16'd39, 16'd12, 8'd4, 8'd2, 8'd1}, // R6
    '{3'd4, 4'd9,  1'b1, 4'd0, 1'b0, 4'd10, 1'b0, 8'd1, 1'b0, 1'b1, 4'd3,  16'd42, 16'd14, 8'd4, 8'd2, 8'd1}, // R3
    '{3'd0, 4'd10, 1'b1, 4'd9, 1'b1, 4'd0,  1'b0, 8'd1, 1'b1, 1'b1, 4'd3,  16'd47, 16'd18, 8'd4, 8'd2, 8'd1}, // R3
    '{3'd4, 4'd0,  1'b0, 4'd0, 1'b0, 4'd15, 1'b0, 8'd1, 1'b1, 1'b1, 4'd5,  16'd48, 16'd18, 8'd4, 8'd2, 8'd1}  // R5
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_valid = 1'b0;
  logic [2:0]  desc_class = '0;
  logic [3:0]  src_a_reg = '0, src_b_reg = '0, dst_reg = '0;
  logic        src_a_vld = 1'b0, src_b_vld = 1'b0, br_taken = 1'b0;
  logic [7:0]  base_cycles = '0;
  logic        grp_first = 1'b0, grp_last = 1'b0;
  logic [31:0] total_cycles, load_stall_cycles, branch_stall_cycles, taken_count, untaken_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stall_acct u_stall_acct (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_class(desc_class),
    .src_a_reg(src_a_reg), .src_a_vld(src_a_vld), .src_b_reg(src_b_reg), .src_b_vld(src_b_vld),
    .dst_reg(dst_reg), .br_taken(br_taken), .base_cycles(base_cycles),
    .grp_first(grp_first), .grp_last(grp_last),
    .total_cycles(total_cycles), .load_stall_cycles(load_stall_cycles),
    .branch_stall_cycles(branch_stall_cycles), .taken_count(taken_count),
    .untaken_count(untaken_count)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input int t, input int l, input int b, input int k, input int u);
    chk(tag, "total", total_cycles, t);
    chk(tag, "load_stall", load_stall_cycles, l);
    chk(tag, "branch_stall", branch_stall_cycles, b);
    chk(tag, "taken", taken_count, k);
    chk(tag, "untaken", untaken_count, u);
  endtask

  // Present one descriptor after a falling edge; return 2 ns after the capturing edge
  task automatic put(input vec_t v);
    @(negedge clk);
    desc_class = v.cls; src_a_reg = v.sa; src_a_vld = v.sav; src_b_reg = v.sb;
    src_b_vld = v.sbv; dst_reg = v.dst; br_taken = v.tk; base_cycles = v.base;
    grp_first = v.first; grp_last = v.last; desc_valid = 1'b1;
    @(posedge clk);
    #2 desc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t d;
    repeat (3) @(posedge clk);
    #2;
    chk_all("R1", 0, 0, 0, 0, 0);
    @(negedge clk) rst = 1'b0;

    // Table walk: counters are due one edge after each descriptor (R9)
    for (int i = 0; i < NV; i++) begin
      put(TBL[i]);
      chk_all($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].et, TBL[i].el, TBL[i].eb, TBL[i].ek, TBL[i].eu);
    end

    // R8: idle cycles change nothing, and the recorded load of r15 survives
    repeat (5) @(posedge clk);
    #2 chk_all("R8", 48, 18, 4, 2, 1);

    // R9: not visible before the edge, visible after; r15 still recorded (R8)
    d = '0;
    d.cls = 3'd0; d.sa = 4'd15; d.sav = 1'b1; d.base = 8'd1; d.first = 1'b1; d.last = 1'b1;
    @(negedge clk);
    desc_class = d.cls; src_a_reg = d.sa; src_a_vld = 1'b1; src_b_vld = 1'b0;
    br_taken = 1'b0; base_cycles = d.base; grp_first = 1'b1; grp_last = 1'b1; desc_valid = 1'b1;
    #3 chk("R9", "total before edge", total_cycles, 48);
    @(posedge clk);
    #2 desc_valid = 1'b0;
    chk("R9", "total after edge", total_cycles, 51);
    chk("R8", "load_stall after idle", load_stall_cycles, 20);

    // R1: reset with a load descriptor present clears counters and the mask
    d.cls = 3'd4; d.dst = 4'd8;
    put(d);
    @(negedge clk) rst = 1'b1;
    desc_valid = 1'b1;
    repeat (2) @(posedge clk);
    #2 desc_valid = 1'b0;
    chk_all("R1", 0, 0, 0, 0, 0);
    @(negedge clk) rst = 1'b0;
    d.cls = 3'd0; d.sa = 4'd8; d.sav = 1'b1;
    put(d);
    chk("R1", "mask cleared total", total_cycles, 1);
    chk("R1", "mask cleared load_stall", load_stall_cycles, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule